// File: doc/BRIEF.md
# DDR Write-Burst Interrupt Masking Unit

This unit sits on the controller side of a DDR memory interface. It decides how a write burst ends when a read arrives before the burst has finished. The write data stream is modelled at the cycle level. One data clock carries a pair of beats, one on each strobe edge, and each beat carries two byte lanes. For every controller clock the unit produces a four-bit beat mask, an enable for the data drivers, an enable for the strobe driver, and a flag that tells the command scheduler whether a read may be issued now.

A write command carries a burst-length code. The unit then drives one data clock per controller clock, starting two cycles after the command. When interrupt support is configured, a read may cut the burst short once the minimum write-to-read spacing has passed. Data clocks shown before the read keep their contents. The data clock aligned with the read is driven fully masked. The beat that follows it is masked while the drivers are already off. The bus is therefore quiet at least one clock before the read data returns, three clocks after the read. When interrupt support is off, a read is held back until the burst is complete and the write-to-read recovery time has passed.

Top module: `ddr_wr_intr_mask`

## Requirements
- R1: While reset is asserted and after reset, `dq_oe` and `dqs_oe` are low, `dm` is 0000 and `rd_ok` is high.
- R2: A write accepted in cycle c with `wr_blen` 01, 10 or 11 (2, 4 or 8 beats) drives 1, 2 or 4 data clocks in consecutive cycles from c+2, with `dq_oe` and `dqs_oe` high and `dm` 0000. A write with code 00 is ignored.
- R3: A write request made while data clocks of an earlier burst are still pending, or in the cycle after a truncation, is ignored. A write is accepted in the cycle in which the last data clock of the previous burst is shown.
- R4: During a burst accepted in cycle c with interrupt support on, `rd_ok` is low in cycle c+1 and high from cycle c+2 until the last data clock has been issued.
- R5: When a read is accepted in cycle R during a burst, every data clock shown up to and including cycle R keeps `dm` 0000.
- R6: In cycle R+1 both drivers are on and `dm` is 1111. Bit 0 is the even beat, low lane (data 7:0). Bit 1 is the even beat, high lane (data 15:8). Bit 2 is the odd beat, low lane. Bit 3 is the odd beat, high lane.
- R7: In cycle R+2 both drivers are off and `dm` is 0011, which masks the beat that follows. No remaining data clock of that burst is ever driven.
- R8: After an accepted interrupting read in cycle R, `dq_oe` and `dqs_oe` are low in cycle R+2, one clock before read data is due in cycle R+3.
- R9: Outside a burst, `rd_ok` is low in the cycle after a truncation and in any cycle fewer than TCDLR (default 3) cycles after the last cycle that showed an unmasked data clock.
- R10: With `cfg_intr_en` low, `rd_ok` stays low for the whole burst, and `dm` never shows 1111.
- R11: A read request made while `rd_ok` is low, or in the same cycle as a write request, is ignored and leaves the drive and mask schedule unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_intr_en | input | 1 | Allows a read to truncate a running write burst |
| wr_req | input | 1 | Write command request |
| wr_blen | input | 2 | Burst-length code: 01=2, 10=4, 11=8 beats, 00 reserved |
| rd_req | input | 1 | Read command request |
| rd_ok | output | 1 | A read may be issued in this cycle |
| dq_oe | output | 1 | Data driver enable |
| dqs_oe | output | 1 | Strobe driver enable |
| dm | output | 4 | Beat mask, two beats by two byte lanes, active high |

## Verification
Every result has a fixed place in time. `rd_ok` is a function of the registered state and the configuration bit, so it is valid in the same cycle. The data clocks of a write accepted in cycle c appear from cycle c+2. For a read accepted in cycle R, the fully masked clock is due at R+1 and the trailing mask with the drivers released at R+2. The bench drives its inputs just after the falling edge, waits a short settle time, and compares all four outputs every cycle against a schedule indexed by cycle number. Its behavioural model writes that schedule at command time, and each command lands at the cycle offsets listed above.

// File: rtl/wim_pkg.sv
package wim_pkg;

    // Burst-length codes as presented on the command port.
    typedef enum logic [1:0] {
        BLEN_NONE = 2'b00,
        BLEN_2    = 2'b01,
        BLEN_4    = 2'b10,
        BLEN_8    = 2'b11
    } blen_code_e;

    // Beats per data clock (one per strobe edge).
    localparam int BEATS_PER_CLK = 2;

    // Number of data clocks a burst occupies; zero for the reserved code.
    function automatic int unsigned clocks_for(input logic [1:0] code);
        int unsigned beats;
        case (blen_code_e'(code))
            BLEN_2:  beats = 2;
            BLEN_4:  beats = 4;
            BLEN_8:  beats = 8;
            default: beats = 0;
        endcase
        return beats / BEATS_PER_CLK;
    endfunction

endpackage

// File: rtl/wim_gap_timer.sv
module wim_gap_timer #(
    parameter int MIN_GAP = 2,
    parameter int TCDLR   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_acc_i,
    input  logic vis_unmasked_i,
    output logic gap_met_o,
    output logic quiet_met_o
);
    localparam int GW = $clog2(MIN_GAP + 1);
    localparam int QW = $clog2(TCDLR + 1);

    typedef struct packed {
        logic [GW-1:0] since_wr;
        logic [QW-1:0] quiet;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        // clocks since the write command, saturating at the spacing limit
        if (wr_acc_i) begin
            d.since_wr = GW'(1);
        end else if (q.since_wr < GW'(MIN_GAP)) begin
            d.since_wr = q.since_wr + GW'(1);
        end
        // clocks since the last unmasked data clock was shown
        if (vis_unmasked_i) begin
            d.quiet = QW'(1);
        end else if (q.quiet < QW'(TCDLR)) begin
            d.quiet = q.quiet + QW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.since_wr <= GW'(MIN_GAP);
            q.quiet    <= QW'(TCDLR);
        end else begin
            q <= d;
        end
    end

    assign gap_met_o   = (q.since_wr >= GW'(MIN_GAP));
    assign quiet_met_o = !vis_unmasked_i && (q.quiet >= QW'(TCDLR));

    // R4: the spacing is never met in the cycle right after a write
    a_r4_gap_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc_i |=> !gap_met_o);

endmodule

// File: rtl/wim_beat_seq.sv
module wim_beat_seq #(
    parameter int LANES      = 2,
    parameter int MAX_CLOCKS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_acc_i,
    input  logic [$clog2(MAX_CLOCKS+1)-1:0] wr_clocks_i,
    input  logic                   cut_i,
    output logic                   busy_o,
    output logic                   tail_o,
    output logic                   dq_oe_o,
    output logic                   dqs_oe_o,
    output logic [2*LANES-1:0]     dm_o
);
    localparam int CW  = $clog2(MAX_CLOCKS + 1);
    localparam int DMW = 2 * LANES;

    // Mask patterns: all beats of a clock, and only the even (first) beat.
    logic [DMW-1:0] dm_all, dm_even;
    for (genvar b = 0; b < DMW; b++) begin : g_masks
        assign dm_all[b]  = 1'b1;
        assign dm_even[b] = (b < LANES);
    end

    typedef struct packed {
        logic [CW-1:0]  left;
        logic           tail;
        logic           dq_oe;
        logic           dqs_oe;
        logic [DMW-1:0] dm;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d        = q;
        d.dq_oe  = 1'b0;
        d.dqs_oe = 1'b0;
        d.dm     = '0;
        d.tail   = 1'b0;
        if (wr_acc_i) begin
            d.left = wr_clocks_i;
        end else if (q.left != '0) begin
            d.dq_oe  = 1'b1;
            d.dqs_oe = 1'b1;
            if (cut_i) begin
                d.dm   = dm_all;
                d.left = '0;
                d.tail = 1'b1;
            end else begin
                d.left = q.left - CW'(1);
            end
        end else if (q.tail) begin
            d.dm = dm_even;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.left != '0);
    assign tail_o   = q.tail;
    assign dq_oe_o  = q.dq_oe;
    assign dqs_oe_o = q.dqs_oe;
    assign dm_o     = q.dm;

    // R6: the clock aligned with the read is driven and fully masked
    a_r6_cut_masked: assert property (@(posedge clk) disable iff (!rst_n)
        cut_i |=> (dq_oe_o && dqs_oe_o && dm_o == dm_all));

    // R7: the following beat is masked with the drivers off
    a_r7_tail_mask: assert property (@(posedge clk) disable iff (!rst_n)
        cut_i |-> ##2 (dm_o == dm_even && !busy_o));

endmodule

// File: rtl/wim_cmd_gate.sv
module wim_cmd_gate #(
    parameter int MAX_CLOCKS = 4
) (
    input  logic       cfg_intr_en_i,
    input  logic       wr_req_i,
    input  logic [1:0] wr_blen_i,
    input  logic       rd_req_i,
    input  logic       busy_i,
    input  logic       tail_i,
    input  logic       gap_met_i,
    input  logic       quiet_met_i,
    output logic       wr_acc_o,
    output logic [$clog2(MAX_CLOCKS+1)-1:0] wr_clocks_o,
    output logic       rd_ok_o,
    output logic       cut_o
);
    import wim_pkg::*;

    localparam int CW = $clog2(MAX_CLOCKS + 1);

    always_comb begin
        wr_clocks_o = CW'(clocks_for(wr_blen_i));
        wr_acc_o    = wr_req_i && (wr_clocks_o != '0) && !busy_i && !tail_i;
        if (busy_i) begin
            rd_ok_o = cfg_intr_en_i && gap_met_i;
        end else begin
            rd_ok_o = !tail_i && quiet_met_i;
        end
        cut_o = rd_req_i && !wr_req_i && rd_ok_o && busy_i;
    end

endmodule

// File: rtl/ddr_wr_intr_mask.sv
module ddr_wr_intr_mask #(
    parameter int LANES   = 2,
    parameter int MIN_GAP = 2,
    parameter int TCDLR   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_intr_en,
    input  logic               wr_req,
    input  logic [1:0]         wr_blen,
    input  logic               rd_req,
    output logic               rd_ok,
    output logic               dq_oe,
    output logic               dqs_oe,
    output logic [2*LANES-1:0] dm
);
    localparam int MAX_CLOCKS = 4;
    localparam int CW         = $clog2(MAX_CLOCKS + 1);
    localparam int DMW        = 2 * LANES;

    logic          wr_acc, cut, busy, tail, gap_met, quiet_met, vis_unmasked;
    logic [CW-1:0] wr_clocks;

    assign vis_unmasked = dq_oe && (dm == '0);

    wim_cmd_gate #(.MAX_CLOCKS(MAX_CLOCKS)) u_gate (
        .cfg_intr_en_i (cfg_intr_en),
        .wr_req_i      (wr_req),
        .wr_blen_i     (wr_blen),
        .rd_req_i      (rd_req),
        .busy_i        (busy),
        .tail_i        (tail),
        .gap_met_i     (gap_met),
        .quiet_met_i   (quiet_met),
        .wr_acc_o      (wr_acc),
        .wr_clocks_o   (wr_clocks),
        .rd_ok_o       (rd_ok),
        .cut_o         (cut)
    );

    wim_gap_timer #(.MIN_GAP(MIN_GAP), .TCDLR(TCDLR)) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_acc_i       (wr_acc),
        .vis_unmasked_i (vis_unmasked),
        .gap_met_o      (gap_met),
        .quiet_met_o    (quiet_met)
    );

    wim_beat_seq #(.LANES(LANES), .MAX_CLOCKS(MAX_CLOCKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_acc_i    (wr_acc),
        .wr_clocks_i (wr_clocks),
        .cut_i       (cut),
        .busy_o      (busy),
        .tail_o      (tail),
        .dq_oe_o     (dq_oe),
        .dqs_oe_o    (dqs_oe),
        .dm_o        (dm)
    );

    // R2: nothing of a new burst shows in the cycle after its command
    a_r2_first_gap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !dq_oe);

    // R4: reads are not legal one clock after an accepted write
    a_r4_no_early_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !rd_ok);

    // R8: bus released one clock before read data returns
    a_r8_bus_release: assert property (@(posedge clk) disable iff (!rst_n)
        cut |-> ##2 (!dq_oe && !dqs_oe));

    // R10: no full mask unless interrupt support was on when the read came
    a_r10_no_cut_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_intr_en) |-> (dm != {DMW{1'b1}}));

    // R9: no read right after the last unmasked data clock of a finished burst
    if (TCDLR > 1) begin : g_r9
        a_r9_recovery: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dq_oe) && $past(dm) == '0 && !busy) |-> !rd_ok);
    end

endmodule

// File: tb/ddr_wr_intr_mask_test.sv
module ddr_wr_intr_mask_test;
    localparam int TCDLR = 3;
    localparam int NC    = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_intr_en = 1'b1;
    logic       wr_req = 1'b0;
    logic       rd_req = 1'b0;
    logic [1:0] wr_blen = 2'b00;
    logic       rd_ok, dq_oe, dqs_oe;
    logic [3:0] dm;

    always #10 clk = ~clk;

    ddr_wr_intr_mask uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_intr_en (cfg_intr_en),
        .wr_req      (wr_req),
        .wr_blen     (wr_blen),
        .rd_req      (rd_req),
        .rd_ok       (rd_ok),
        .dq_oe       (dq_oe),
        .dqs_oe      (dqs_oe),
        .dm          (dm)
    );

    int checks = 0;
    int errors = 0;
    int t = 0;
    bit cfg_v = 1'b1;
    bit done = 1'b0;

    // Reference schedule, indexed by cycle number.
    bit         exp_oe [NC];
    logic [3:0] exp_dm [NC];
    int wr_c = -100, busy_until = -100, tail_cyc = -100;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, t, act, exp);
        end
    endtask

    function automatic bit model_quiet();
        for (int k = 0; k < TCDLR; k++) begin
            if (t - k >= 0 && exp_oe[t-k] && exp_dm[t-k] == 4'h0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic step(bit w, logic [1:0] code, bit r);
        bit busy, tail, ok;
        int n;
        string tg;
        @(negedge clk);
        cfg_intr_en = cfg_v;
        wr_req  = w;
        wr_blen = code;
        rd_req  = r;
        #1;
        busy = (t > wr_c) && (t <= busy_until);
        tail = (t == tail_cyc);
        ok   = busy ? (cfg_v && (t - wr_c >= 2)) : (!tail && model_quiet());
        // R4 / R10 inside a burst, R9 outside
        chk(busy ? (cfg_v ? "R4" : "R10") : "R9", "rd_ok", int'(rd_ok), int'(ok));
        if (exp_dm[t] == 4'hF)      tg = "R6";
        else if (exp_dm[t] == 4'h3) tg = "R7";
        else if (exp_oe[t])         tg = "R2";
        else                        tg = "R8";
        chk(tg, "dq_oe",  int'(dq_oe),  int'(exp_oe[t]));
        chk(tg, "dqs_oe", int'(dqs_oe), int'(exp_oe[t]));
        chk(tg, "dm",     int'(dm),     int'(exp_dm[t]));
        n = (code == 2'b01) ? 1 : (code == 2'b10) ? 2 : (code == 2'b11) ? 4 : 0;
        if (w && !busy && !tail && n > 0) begin
            wr_c = t;
            busy_until = t + n;
            for (int j = 1; j <= n; j++) begin
                exp_oe[t+j+1] = 1'b1;
                exp_dm[t+j+1] = 4'h0;
            end
        end else if (r && !w && ok && busy) begin
            for (int s = t + 1; s <= t + 6; s++) begin
                exp_oe[s] = 1'b0;
                exp_dm[s] = 4'h0;
            end
            exp_oe[t+1] = 1'b1;
            exp_dm[t+1] = 4'hF;
            exp_dm[t+2] = 4'h3;
            busy_until = t;
            tail_cyc = t + 1;
        end
        t++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'b00, 1'b0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) begin
            exp_oe[i] = 1'b0;
            exp_dm[i] = 4'h0;
        end
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk("R1", "dq_oe",  int'(dq_oe),  0);
            chk("R1", "dqs_oe", int'(dqs_oe), 0);
            chk("R1", "dm",     int'(dm),     0);
            chk("R1", "rd_ok",  int'(rd_ok),  1);
        end
        rst_n = 1'b1;
        idle(2);
        // R2: each burst length, and the reserved code
        step(1'b1, 2'b11, 1'b0); idle(8);
        step(1'b1, 2'b01, 1'b0); idle(5);
        step(1'b1, 2'b10, 1'b0); idle(6);
        step(1'b1, 2'b00, 1'b0); idle(4);
        // R3: writes while a burst is pending are dropped
        step(1'b1, 2'b11, 1'b0); step(1'b0, 2'b00, 1'b0); step(1'b1, 2'b01, 1'b0); idle(8);
        // R3: back-to-back short bursts
        step(1'b1, 2'b01, 1'b0); step(1'b1, 2'b01, 1'b0); step(1'b1, 2'b01, 1'b0); idle(6);
        // R4 / R11: read one clock after write is blocked, next clock cuts (R5, R6, R7, R8)
        step(1'b1, 2'b11, 1'b0); step(1'b0, 2'b00, 1'b1); step(1'b0, 2'b00, 1'b1); idle(8);
        // R5: cut on the last data clock of the burst
        step(1'b1, 2'b11, 1'b0); idle(3); step(1'b0, 2'b00, 1'b1); idle(6);
        // R11: read together with write ignored, read in the tail cycle ignored
        step(1'b1, 2'b11, 1'b0); idle(2); step(1'b1, 2'b01, 1'b1);
        step(1'b0, 2'b00, 1'b1); step(1'b0, 2'b00, 1'b1); idle(6);
        // R9: reads right after a finished burst wait for recovery
        step(1'b1, 2'b10, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b0, 2'b00, 1'b1);
        idle(3);
        // R10: interrupt support off, reads held for the whole burst
        cfg_v = 1'b0;
        step(1'b1, 2'b11, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b0, 2'b00, 1'b1);
        idle(3);
        cfg_v = 1'b1;
        idle(3);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still going, expected finished");
            summary();
            $finish;
        end
    end

endmodule